// File: doc/BRIEF.md
# Top-Aligned Flash Write Protection Unit

This block decides, for each program or erase request, whether the target address falls inside a write-protected window at the top of a 64 KB flash address map. The window always ends at 0xFFFF and starts on a 512-byte boundary. An 8-bit protection setting picks that boundary. Its upper seven bits are the upper seven bits of the highest writable address, and the nine bits below them are taken as ones. Its lowest bit switches protection off.

The setting register takes its value from a nonvolatile protection byte as reset ends. Application software cannot change it. Writes from software are dropped, and only the debug write port can replace the setting. This lets a debugger unlock and reprogram protected flash, while a runaway program cannot remove the protection.

The flash controller presents a candidate address with a program/erase qualifier. The unit answers in the same cycle with a violation flag, which the controller uses to refuse the command.

Top module: `flash_wprot`

## Requirements
- R1: `violation_o` is 1 in the same cycle, combinationally, when `acc_valid_i`=1, `acc_is_mod_i`=1, protection is enabled and `acc_addr_i` is strictly greater than the highest writable address. Otherwise it is 0.
- R2: The highest writable address is {setting[7:1], 9'h1FF}. For example, setting 0xF8 gives 0xF9FF as the highest writable address, so 0xFA00 to 0xFFFF (1536 bytes) are protected.
- R3: Setting bit 0 = 1 disables protection, and no request is then flagged. Setting bit 0 = 0 enables protection.
- R4: A read request (`acc_is_mod_i`=0) never raises `violation_o`.
- R5: `rst_n` is asserted asynchronously and its release passes through a 2-stage synchronizer. On the first clock edge after the synchronized release, the setting is loaded from `nv_prot_i`. Later changes to `nv_prot_i` have no effect until the next reset.
- R6: Until that load has happened, including while `rst_n` is low, every valid program/erase request is flagged, whatever its address.
- R7: Writes on the software port (`sw_wr_i`, `sw_wdata_i`) never change the setting.
- R8: A debug write (`dbg_wr_i`) replaces the setting at the next clock edge, so a request in the same cycle as the write still sees the old setting. If a debug write coincides with the reset load, the load wins.
- R9: Setting select bits 0x7F with protection enabled protect nothing. Select bits 0x00 leave only 0x0000 to 0x01FF writable.
- R10: With `acc_valid_i`=0, `violation_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_prot_i | input | 8 | Nonvolatile protection byte image |
| sw_wr_i | input | 1 | Software write strobe to the setting (ignored) |
| sw_wdata_i | input | 8 | Software write data (ignored) |
| dbg_wr_i | input | 1 | Debug write strobe to the setting |
| dbg_wdata_i | input | 8 | Debug write data |
| acc_valid_i | input | 1 | Candidate access present |
| acc_is_mod_i | input | 1 | 1 = program or erase, 0 = read |
| acc_addr_i | input | 16 | Candidate flash address |
| violation_o | output | 1 | Request targets the protected window |

## Verification
The bench probes both sides of the window edge: 0xF9FF against 0xFA00 for setting 0xF8, and the extreme settings where the window is empty or covers everything above 0x01FF. An off-by-one comparator would flag 0xF9FF or pass 0xFA00, and an inverted disable bit would flag everything once protection was turned off. It also drives a debug write in the reset-load cycle, where a wrong priority would leave the debug value in place of the nonvolatile one. It watches the cycles before the load, where a design without the fail-safe would let writes through. Software writes and late changes to the nonvolatile byte are applied between checks, to catch a register that accepts them.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;
  parameter int ADDR_W    = 16;
  parameter int PAGE_LOG2 = 9;
  localparam int SEL_W    = ADDR_W - PAGE_LOG2;
  localparam int SET_W    = SEL_W + 1;

  // Layout matters: upper bits are the boundary select, bit 0 turns protection off.
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             off;
  } prot_set_t;
endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wprot_set_reg.sv
module wprot_set_reg
  import flash_wprot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  prot_set_t nv_i,
  input  logic      sw_wr_i,
  input  logic      dbg_wr_i,
  input  prot_set_t dbg_data_i,
  output prot_set_t set_o,
  output logic      pending_o
);
  prot_set_t set_q, set_d;
  logic      pend_q, pend_d;
  logic      set_en;

  // Software writes are deliberately not a term of the enable.
  assign set_en = pend_q | dbg_wr_i;

  always_comb begin
    set_d  = set_q;
    pend_d = pend_q;
    if (pend_q) begin
      set_d  = nv_i;
      pend_d = 1'b0;
    end else if (dbg_wr_i) begin
      set_d = dbg_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '1;
      pend_q <= 1'b1;
    end else begin
      if (set_en) set_q <= set_d;
      pend_q <= pend_d;
    end
  end

  assign set_o     = set_q;
  assign pending_o = pend_q;

  // R5: load captures the nonvolatile byte
  a_r5_load_nv: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (set_q == $past(nv_i)));
  // R5: load happens once per reset
  a_r5_load_once: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> !pend_q);
  // R7: software writes leave the setting untouched
  a_r7_sw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && !dbg_wr_i && !pend_q) |=> $stable(set_q));
  // R8: debug write lands on the next edge
  a_r8_dbg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr_i && !pend_q) |=> (set_q == $past(dbg_data_i)));
endmodule

// File: rtl/wprot_addr_cmp.sv
module wprot_addr_cmp
  import flash_wprot_pkg::*;
(
  input  logic [SEL_W-1:0] page_i,
  input  prot_set_t        set_i,
  output logic             in_window_o
);
  // An address is past the last writable byte exactly when its page index exceeds the select.
  always_comb begin
    in_window_o = !set_i.off && (page_i > set_i.sel);
  end
endmodule

// File: rtl/flash_wprot.sv
module flash_wprot
  import flash_wprot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  nv_prot_i,
  input  logic              sw_wr_i,
  input  logic [SET_W-1:0]  sw_wdata_i,
  input  logic              dbg_wr_i,
  input  logic [SET_W-1:0]  dbg_wdata_i,
  input  logic              acc_valid_i,
  input  logic              acc_is_mod_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              violation_o
);
  logic      rst_sync_n;
  prot_set_t set_cur;
  logic      pending;
  logic      in_window;
  logic      sw_unused;

  assign sw_unused = ^sw_wdata_i;

  wprot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wprot_set_reg u_set_reg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .nv_i       (prot_set_t'(nv_prot_i)),
    .sw_wr_i    (sw_wr_i),
    .dbg_wr_i   (dbg_wr_i),
    .dbg_data_i (prot_set_t'(dbg_wdata_i)),
    .set_o      (set_cur),
    .pending_o  (pending)
  );

  wprot_addr_cmp u_addr_cmp (
    .page_i      (acc_addr_i[ADDR_W-1:PAGE_LOG2]),
    .set_i       (set_cur),
    .in_window_o (in_window)
  );

  // Before the load completes the request is refused (fail-safe).
  assign violation_o = acc_valid_i && acc_is_mod_i && (pending || in_window);

  // R4: reads are never refused
  a_r4_read_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid_i && !acc_is_mod_i) |-> !violation_o);
  // R10: no request, no flag
  a_r10_idle_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid_i |-> !violation_o);
  // R9: the lowest page is writable once loaded
  a_r9_low_page: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pending && acc_addr_i[ADDR_W-1:PAGE_LOG2] == '0) |-> !violation_o);
endmodule

// File: tb/flash_wprot_tb.sv
module flash_wprot_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  nv_prot_i;
  logic        sw_wr_i;
  logic [7:0]  sw_wdata_i;
  logic        dbg_wr_i;
  logic [7:0]  dbg_wdata_i;
  logic        acc_valid_i;
  logic        acc_is_mod_i;
  logic [15:0] acc_addr_i;
  logic        violation_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wprot u_dut (
    .clk, .rst_n, .nv_prot_i, .sw_wr_i, .sw_wdata_i, .dbg_wr_i, .dbg_wdata_i,
    .acc_valid_i, .acc_is_mod_i, .acc_addr_i, .violation_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: violation actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive a request mid-cycle and sample the combinational answer.
  task automatic probe(input string req, input logic valid, input logic is_mod,
                       input logic [15:0] addr, input logic exp);
    acc_valid_i  = valid;
    acc_is_mod_i = is_mod;
    acc_addr_i   = addr;
    #1;
    chk(req, violation_o, exp);
  endtask

  task automatic dbg_write(input logic [7:0] val);
    @(negedge clk);
    dbg_wr_i = 1'b1; dbg_wdata_i = val;
    @(negedge clk);
    dbg_wr_i = 1'b0;
  endtask

  // R5/R6: reset, fail-safe window, then load
  task automatic t_reset_load(input logic [7:0] nv);
    @(negedge clk);
    rst_n = 1'b0; nv_prot_i = nv;
    probe("R6 in reset", 1, 1, 16'h0000, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    probe("R6 before load", 1, 1, 16'h0000, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_nv_sticky;
    t_reset_load(8'hFF);
    probe("R5 loaded disabled", 1, 1, 16'hFFFF, 1'b0);
    nv_prot_i = 8'h00;
    @(negedge clk); @(negedge clk);
    probe("R5 late nv change", 1, 1, 16'hFFFF, 1'b0);
  endtask

  task automatic t_nv_value;
    t_reset_load(8'hF8);
    probe("R5 nv F8 top", 1, 1, 16'hFA00, 1'b1);
    probe("R5 nv F8 below", 1, 1, 16'hF9FF, 1'b0);
  endtask

  task automatic t_boundary;
    dbg_write(8'hF8);
    probe("R2 last writable", 1, 1, 16'hF9FF, 1'b0);
    probe("R1 R2 first protected", 1, 1, 16'hFA00, 1'b1);
    probe("R1 top", 1, 1, 16'hFFFF, 1'b1);
    probe("R4 read in window", 1, 0, 16'hFA00, 1'b0);
    probe("R10 not valid", 0, 1, 16'hFA00, 1'b0);
  endtask

  task automatic t_disable;
    dbg_write(8'hF9);
    probe("R3 disabled", 1, 1, 16'hFA00, 1'b0);
    probe("R3 disabled top", 1, 1, 16'hFFFF, 1'b0);
  endtask

  task automatic t_dbg_timing;
    dbg_write(8'hF9);
    @(negedge clk);
    dbg_wr_i = 1'b1; dbg_wdata_i = 8'hF8;
    probe("R8 same cycle old value", 1, 1, 16'hFA00, 1'b0);
    @(negedge clk);
    dbg_wr_i = 1'b0;
    probe("R8 next cycle new value", 1, 1, 16'hFA00, 1'b1);
  endtask

  task automatic t_sw_ignored;
    dbg_write(8'hF8);
    @(negedge clk);
    sw_wr_i = 1'b1; sw_wdata_i = 8'hFF;
    @(negedge clk);
    sw_wr_i = 1'b0;
    probe("R7 sw disable ignored", 1, 1, 16'hFA00, 1'b1);
    @(negedge clk);
    sw_wr_i = 1'b1; sw_wdata_i = 8'h00;
    @(negedge clk);
    sw_wr_i = 1'b0;
    probe("R7 sw widen ignored", 1, 1, 16'h0200, 1'b0);
  endtask

  task automatic t_extremes;
    dbg_write(8'hFE);
    probe("R9 sel 7F top free", 1, 1, 16'hFFFF, 1'b0);
    dbg_write(8'h00);
    probe("R9 sel 0 low page", 1, 1, 16'h01FF, 1'b0);
    probe("R9 sel 0 second page", 1, 1, 16'h0200, 1'b1);
  endtask

  task automatic t_load_beats_dbg;
    @(negedge clk);
    rst_n = 1'b0; nv_prot_i = 8'hF8;
    dbg_wr_i = 1'b1; dbg_wdata_i = 8'hFF;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    dbg_wr_i = 1'b0;
    probe("R8 load wins collision", 1, 1, 16'hFA00, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; nv_prot_i = 8'hFF; sw_wr_i = 0; sw_wdata_i = 0;
    dbg_wr_i = 0; dbg_wdata_i = 0; acc_valid_i = 0; acc_is_mod_i = 0; acc_addr_i = 0;
    t_nv_sticky();
    t_boundary();
    t_disable();
    t_dbg_timing();
    t_sw_ignored();
    t_extremes();
    t_nv_value();
    t_load_beats_dbg();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule